// File: doc/BRIEF.md
# Triggered Circular Trace Capture Buffer

This block records a stream of trace words into a circular on-chip RAM while capture is switched on. Each incoming word passes through a one-entry staging register and is then written at the write pointer, which wraps at the end of the RAM. When a trigger is seen, capture goes on for a programmed number of further words and then stops by itself. This gives a window of history around the event of interest.

Debug software drives the block through a small synchronous register port. It arms the post-trigger count, clears the write pointer and sets the enable bit. It then polls a status register that shows wrap, trigger, completion and drain. Afterwards it sets the read pointer to the oldest entry and drains the RAM one word per data-register read. Every such read advances the read pointer.

Top module: `trace_ring_buf`

## Requirements
- R1: After reset, the following registers all read 0: status (address 3), read pointer (5), write pointer (6), post-trigger count (7) and control (8).
- R2: Address 0 reads the constant `ID_CODE`, address 1 reads `DEPTH` and address 2 reads `WIDTH`. Writes to addresses 0 to 4 change no register.
- R3: While control bit 0 is 1, each word offered with `trcValid` high is stored at the write pointer two clock edges later. The write pointer then steps by one modulo `DEPTH`. A store at entry `DEPTH-1` sets status bit 0 (wrapped). With control bit 0 at 0, words are not stored.
- R4: A `trcTrigger` pulse seen while capture is on sets status bit 1 (triggered), which stays set. A trigger seen while capture is off has no effect.
- R5: With post-trigger count N, the word offered with the trigger is stored, followed by exactly N further words. Status bit 2 (complete) then sets, no further word is stored and the count reads 0.
- R6: Status bit 3 (drained) is high when complete is set and no staged word is pending. It rises no later than one cycle after complete.
- R7: Reading address 4 with `regRd` high returns the RAM word at the read pointer, zero-extended. The read pointer then steps by one modulo `DEPTH`.
- R8: Writing address 5 or 6 loads the read or write pointer, and writing address 7 loads the post-trigger count. Each reads back the value written.
- R9: Address 8 holds control bits [1:0]: bit 0 enables capture and bit 1 is the demultiplexed-port mode bit. Writing bit 0 to 1 while it is 0 clears status bits 0 to 3. Turning capture off leaves them as they are.
- R10: Addresses 9 to 127 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| trcValid | input | 1 | Trace word valid |
| trcData | input | WIDTH | Trace word |
| trcTrigger | input | 1 | Trigger event |
| regAddr | input | 7 | Register address |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe (advances the read pointer at address 4) |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data, combinational from `regAddr` |

## Verification
The assertions assume that software does not turn capture back on in the same cycle that a staged word is still being written. They also assume that software does not rewrite the write pointer while capture runs. The bench keeps to both: before it touches the write pointer or re-arms, it always writes control to 0 and then lets the staging register empty. Within those limits, the bench sweeps the post-trigger count over every value from 0 to `DEPTH-1` with the trigger on a fixed word. This covers runs that stop before the RAM wraps and runs that overwrite older entries. For each run the bench checks the whole drained window, the oldest word first.

// File: rtl/trace_ring_pkg.sv
package trace_ring_pkg;

  localparam int REG_W  = 32;
  localparam int ADDR_W = 7;

  typedef enum logic [ADDR_W-1:0] {
    A_IDENT  = 7'd0,
    A_DEPTH  = 7'd1,
    A_WIDTH  = 7'd2,
    A_STATUS = 7'd3,
    A_DATA   = 7'd4,
    A_RDPTR  = 7'd5,
    A_WRPTR  = 7'd6,
    A_TCOUNT = 7'd7,
    A_CTRL   = 7'd8
  } reg_addr_e;

  // Strobes from control to datapath, one cycle each.
  typedef struct packed {
    logic stageLd;  // capture trcData into the staging register
    logic store;    // write the staged word at wrPtr, step wrPtr
    logic ldWr;     // load wrPtr from ptrVal
    logic ldRd;     // load rdPtr from ptrVal
    logic incRd;    // step rdPtr after a data read
  } dp_strobe_t;

endpackage

// File: rtl/trace_ring_dp.sv
module trace_ring_dp
  import trace_ring_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int WIDTH = 16,
  parameter int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  dp_strobe_t       strobe,
  input  logic [WIDTH-1:0] trcData,
  input  logic [PTR_W-1:0] ptrVal,
  output logic [PTR_W-1:0] wrPtr,
  output logic [PTR_W-1:0] rdPtr,
  output logic [WIDTH-1:0] ramQ
);

  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam bit POW2 = (DEPTH & (DEPTH - 1)) == 0;

  logic [WIDTH-1:0] stgData;
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrNext, rdNext;

  // Wrap arithmetic: free overflow for power-of-two depths, compare otherwise.
  generate
    if (POW2) begin : g_wrap_free
      assign wrNext = wrPtr + 1'b1;
      assign rdNext = rdPtr + 1'b1;
    end else begin : g_wrap_cmp
      assign wrNext = (wrPtr == LAST) ? '0 : wrPtr + 1'b1;
      assign rdNext = (rdPtr == LAST) ? '0 : rdPtr + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stgData <= '0;
    end else if (strobe.stageLd) begin
      stgData <= trcData;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.store) begin
      mem[wrPtr] <= stgData;
    end
  end

  assign ramQ = mem[rdPtr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
    end else if (strobe.ldWr) begin
      wrPtr <= ptrVal;
    end else if (strobe.store) begin
      wrPtr <= wrNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPtr <= '0;
    end else if (strobe.ldRd) begin
      rdPtr <= ptrVal;
    end else if (strobe.incRd) begin
      rdPtr <= rdNext;
    end
  end

  // R7: a data read steps the read pointer by one, wrapping at the end.
  p_rdptr_step_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.incRd && !strobe.ldRd |=>
      rdPtr == (($past(rdPtr) == LAST) ? '0 : $past(rdPtr) + 1'b1));

  // R8: a pointer load takes the written value.
  p_wrptr_load_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.ldWr |=> wrPtr == $past(ptrVal));

endmodule

// File: rtl/trace_ring_ctrl.sv
module trace_ring_ctrl
  import trace_ring_pkg::*;
#(
  parameter int          DEPTH   = 16,
  parameter int          WIDTH   = 16,
  parameter logic [31:0] ID_CODE = 32'h7B0C_0001,
  parameter int          PTR_W   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              trcValid,
  input  logic              trcTrigger,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [REG_W-1:0]  regWdata,
  input  logic [PTR_W-1:0]  wrPtr,
  input  logic [PTR_W-1:0]  rdPtr,
  input  logic [WIDTH-1:0]  ramQ,
  output dp_strobe_t        strobe,
  output logic [PTR_W-1:0]  ptrVal,
  output logic [REG_W-1:0]  regRdata
);

  localparam int CNT_W = PTR_W + 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic             ctrlEn, ctrlDemux;
  logic             full, triggered, acqComp;
  logic [CNT_W-1:0] cnt;
  logic             stgValid, stgTrig;
  logic             capOk, done, reEnable, dfEmpty;
  logic             wrCtrl, wrCount;
  logic             unusedBits;

  assign unusedBits = ^regWdata[REG_W-1:CNT_W];

  assign capOk    = ctrlEn && !acqComp;
  assign done     = triggered && (cnt == '0);
  assign wrCtrl   = regWr && (regAddr == A_CTRL);
  assign wrCount  = regWr && (regAddr == A_TCOUNT);
  assign reEnable = wrCtrl && regWdata[0] && !ctrlEn;
  assign dfEmpty  = acqComp && !stgValid;
  assign ptrVal   = regWdata[PTR_W-1:0];

  always_comb begin
    strobe         = '0;
    strobe.stageLd = capOk && trcValid;
    strobe.ldWr    = regWr && (regAddr == A_WRPTR);
    strobe.ldRd    = regWr && (regAddr == A_RDPTR);
    strobe.incRd   = regRd && (regAddr == A_DATA);
    strobe.store   = stgValid && !acqComp && !done && !strobe.ldWr;
  end

  // Input staging flags.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stgValid <= 1'b0;
      stgTrig  <= 1'b0;
    end else begin
      stgValid <= capOk && trcValid;
      stgTrig  <= capOk && trcTrigger;
    end
  end

  // Control register.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlEn    <= 1'b0;
      ctrlDemux <= 1'b0;
    end else if (wrCtrl) begin
      ctrlEn    <= regWdata[0];
      ctrlDemux <= regWdata[1];
    end
  end

  // Sticky status flags.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      full      <= 1'b0;
      triggered <= 1'b0;
      acqComp   <= 1'b0;
    end else if (reEnable) begin
      full      <= 1'b0;
      triggered <= 1'b0;
      acqComp   <= 1'b0;
    end else begin
      if (strobe.store && wrPtr == LAST) full <= 1'b1;
      if (stgTrig)                       triggered <= 1'b1;
      if (done)                          acqComp <= 1'b1;
    end
  end

  // Post-trigger word counter.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (wrCount) begin
      cnt <= regWdata[CNT_W-1:0];
    end else if (strobe.store && triggered) begin
      cnt <= cnt - 1'b1;
    end
  end

  // Register read mux.
  always_comb begin
    regRdata = '0;
    case (regAddr)
      A_IDENT:  regRdata = ID_CODE;
      A_DEPTH:  regRdata = REG_W'(DEPTH);
      A_WIDTH:  regRdata = REG_W'(WIDTH);
      A_STATUS: regRdata = {28'd0, dfEmpty, acqComp, triggered, full};
      A_DATA:   regRdata = REG_W'(ramQ);
      A_RDPTR:  regRdata = REG_W'(rdPtr);
      A_WRPTR:  regRdata = REG_W'(wrPtr);
      A_TCOUNT: regRdata = REG_W'(cnt);
      A_CTRL:   regRdata = {30'd0, ctrlDemux, ctrlEn};
      default:  regRdata = '0;
    endcase
  end

  // R3: storing into the last entry marks the buffer as wrapped.
  p_full_on_wrap_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.store && wrPtr == LAST && !reEnable |=> full);

  // R4: the triggered flag only clears on re-arm.
  p_trig_sticky_r4: assert property (@(posedge clk) disable iff (!rstN)
    triggered && !reEnable |=> triggered);

  // R5: completion implies a trigger was seen.
  p_comp_after_trig_r5: assert property (@(posedge clk) disable iff (!rstN)
    acqComp |-> triggered);

  // R5: after completion the write pointer moves only by register load.
  p_wrptr_frozen_r5: assert property (@(posedge clk) disable iff (!rstN)
    acqComp && !strobe.ldWr |=> $stable(wrPtr));

  // R6: one cycle after completion the staging register is empty.
  p_drained_r6: assert property (@(posedge clk) disable iff (!rstN)
    acqComp && $past(acqComp) |-> dfEmpty);

endmodule

// File: rtl/trace_ring_buf.sv
module trace_ring_buf
  import trace_ring_pkg::*;
#(
  parameter int          DEPTH   = 16,
  parameter int          WIDTH   = 16,
  parameter logic [31:0] ID_CODE = 32'h7B0C_0001
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              trcValid,
  input  logic [WIDTH-1:0]  trcData,
  input  logic              trcTrigger,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [REG_W-1:0]  regWdata,
  output logic [REG_W-1:0]  regRdata
);

  localparam int PTR_W = $clog2(DEPTH);

  dp_strobe_t       strobe;
  logic [PTR_W-1:0] ptrVal, wrPtr, rdPtr;
  logic [WIDTH-1:0] ramQ;

  trace_ring_ctrl #(
    .DEPTH(DEPTH), .WIDTH(WIDTH), .ID_CODE(ID_CODE), .PTR_W(PTR_W)
  ) i_ctrl (
    .clk(clk), .rstN(rstN),
    .trcValid(trcValid), .trcTrigger(trcTrigger),
    .regAddr(regAddr), .regWr(regWr), .regRd(regRd), .regWdata(regWdata),
    .wrPtr(wrPtr), .rdPtr(rdPtr), .ramQ(ramQ),
    .strobe(strobe), .ptrVal(ptrVal), .regRdata(regRdata)
  );

  trace_ring_dp #(
    .DEPTH(DEPTH), .WIDTH(WIDTH), .PTR_W(PTR_W)
  ) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .trcData(trcData),
    .ptrVal(ptrVal), .wrPtr(wrPtr), .rdPtr(rdPtr), .ramQ(ramQ)
  );

endmodule

// File: tb/test_trace_ring_buf.sv
module test_trace_ring_buf;

  localparam int          DEPTH = 16;
  localparam int          WIDTH = 16;
  localparam logic [31:0] IDC   = 32'h7B0C_0001;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        trcValid = 1'b0;
  logic [15:0] trcData = '0;
  logic        trcTrigger = 1'b0;
  logic [6:0]  regAddr = '0;
  logic        regWr = 1'b0;
  logic        regRd = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;

  int nChk = 0;
  int nBad = 0;

  always #2 clk = ~clk;  // 250 MHz

  trace_ring_buf #(.DEPTH(DEPTH), .WIDTH(WIDTH), .ID_CODE(IDC)) i_trace_ring_buf (
    .clk(clk), .rstN(rstN), .trcValid(trcValid), .trcData(trcData),
    .trcTrigger(trcTrigger), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .regWdata(regWdata), .regRdata(regRdata)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [6:0] a, input logic [31:0] v);
    @(negedge clk);
    regAddr = a; regWdata = v; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic regRead(input logic [6:0] a, output logic [31:0] v);
    @(negedge clk);
    regAddr = a; regRd = 1'b1;
    #1 v = regRdata;
    @(posedge clk);
    #1 regRd = 1'b0;
  endtask

  task automatic pushWord(input logic [15:0] d, input logic tg);
    @(negedge clk);
    trcValid = 1'b1; trcData = d; trcTrigger = tg;
  endtask

  task automatic pushIdle();
    @(negedge clk);
    trcValid = 1'b0; trcTrigger = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    regRead(7'd3, v); check("R1 status", v, 32'd0);
    regRead(7'd5, v); check("R1 rdptr", v, 32'd0);
    regRead(7'd6, v); check("R1 wrptr", v, 32'd0);
    regRead(7'd7, v); check("R1 count", v, 32'd0);
    regRead(7'd8, v); check("R1 ctrl", v, 32'd0);

    // R2: constants, and writes to read-only addresses are ignored
    for (int a = 0; a < 5; a++) regWrite(7'(a), 32'hFFFF_FFFF);
    regRead(7'd0, v); check("R2 ident", v, IDC);
    regRead(7'd1, v); check("R2 depth", v, DEPTH);
    regRead(7'd2, v); check("R2 width", v, WIDTH);
    regRead(7'd3, v); check("R2 status unchanged", v, 32'd0);
    regRead(7'd5, v); check("R2 rdptr unchanged", v, 32'd0);

    // R10: unmapped addresses
    regRead(7'd9, v);   check("R10 addr 9", v, 32'd0);
    regRead(7'd127, v); check("R10 addr 127", v, 32'd0);

    // R3 R4: capture disabled -> nothing stored, trigger ignored
    for (int i = 0; i < 5; i++) pushWord(16'(i), i == 2);
    pushIdle();
    repeat (3) @(negedge clk);
    regRead(7'd6, v); check("R3 no store when off", v, 32'd0);
    regRead(7'd3, v); check("R4 trigger ignored when off", v, 32'd0);

    // R8: pointer and count load/readback
    regWrite(7'd5, 32'd11); regRead(7'd5, v); check("R8 rdptr load", v, 32'd11);
    regWrite(7'd6, 32'd9);  regRead(7'd6, v); check("R8 wrptr load", v, 32'd9);
    regWrite(7'd7, 32'd12); regRead(7'd7, v); check("R8 count load", v, 32'd12);

    // R3 R5 R6 R7: sweep of the post-trigger count, trigger on word 3
    for (int n = 0; n < DEPTH; n++) begin
      int s, first, num;
      regWrite(7'd8, 32'd0);
      regWrite(7'd6, 32'd0);
      regWrite(7'd7, 32'(n));
      regWrite(7'd8, 32'd1);
      for (int i = 0; i < 30; i++) pushWord({8'(n), 8'(i)}, i == 3);
      pushIdle();
      repeat (4) @(negedge clk);
      s = 4 + n;
      regRead(7'd3, v);
      check("R5 R6 status", v, {28'd0, 1'b1, 1'b1, 1'b1, (s >= DEPTH)});
      regRead(7'd6, v); check("R3 wrptr after run", v, 32'(s % DEPTH));
      regRead(7'd7, v); check("R5 count exhausted", v, 32'd0);
      first = (s >= DEPTH) ? (s % DEPTH) : 0;
      num   = (s >= DEPTH) ? DEPTH : s;
      regWrite(7'd5, 32'(first));
      for (int k = 0; k < num; k++) begin
        regRead(7'd4, v);
        check("R7 data word", v, {16'd0, 8'(n), 8'(s - num + k)});
      end
      regRead(7'd5, v); check("R7 rdptr after drain", v, 32'((first + num) % DEPTH));
    end

    // R9: disabling keeps status, re-arming clears it, mode bit readback
    regWrite(7'd8, 32'd0);
    regRead(7'd3, v); check("R9 status kept when off", v, 32'hF);
    regWrite(7'd8, 32'd1);
    regRead(7'd3, v); check("R9 status cleared on re-arm", v, 32'd0);
    regWrite(7'd8, 32'd3);
    regRead(7'd8, v); check("R9 ctrl readback", v, 32'd3);
    regWrite(7'd8, 32'd0);
    regRead(7'd8, v); check("R9 ctrl off", v, 32'd0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule